// File: doc/BRIEF.md
# I/Q Sample Word Serializer

This block turns a stream of complex baseband samples into serial words. Each 15-bit two's-complement sample becomes a 16-bit word: the sample comes first, most significant bit first, and a one-bit flag fills the last position. The flag marks the word as in-phase (0) or quadrature (1), so both halves of a pair can share one data line. Each word opens with a one-cycle frame sync, and one bit leaves per master-clock cycle.

Streaming runs while either an enable register bit or an enable pin is high. Time is divided into slots of `SLOT_CYCLES` master-clock cycles, 48 by default. Each slot carries one pair: the in-phase word starts at slot offset 0 and the quadrature word at offset `SLOT_CYCLES/2`. Samples arrive as a parallel pair with a valid strobe. The pair sent in a slot is the newest one seen up to and including the slot's first cycle. If no new pair has arrived, the previous pair is sent again.

There are two serial ports, A and B. A select input chooses which one carries the stream. The select input is captured only when streaming starts, and the port that is not chosen stays silent.

Top module: `iq_word_serializer`

## Requirements
- R1: Each word is sent most significant bit first, one bit per cycle. Bits 15 down to 1 of the word are the sample bits 14 down to 0. Between words the data line is 0.
- R2: The last bit of a word (bit 0) is the flag. It is 0 on the in-phase word and 1 on the quadrature word.
- R3: Within a slot, the in-phase word starts at offset 0 and the quadrature word starts at offset SLOT_CYCLES/2.
- R4: Slots repeat every SLOT_CYCLES cycles, so a new in-phase word starts every SLOT_CYCLES cycles while streaming.
- R5: Streaming starts on the clock edge at which en_reg or en_pin is high while the block is idle. Its first frame sync appears in the cycle after that edge. When both enables are low at an edge, `streaming`, every frame sync and every data line are 0 from that edge on.
- R6: When port_sel is 1, the stream is sent on port A. When port_sel is 0, it is sent on port B. The other port's frame sync and data stay 0.
- R7: port_sel is sampled at the edge where streaming starts. Changes to it while streaming have no effect on the routing.
- R8: A slot sends the last pair accepted with smp_valid at or before the edge that starts the slot. If no pair has been accepted since the last slot, the previous pair is sent again. The held pair is all zeros after reset.
- R9: The frame sync is high for exactly the first bit cycle of each word.
- R10: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_reg | input | 1 | Enable bit from the control register |
| en_pin | input | 1 | Enable pin |
| port_sel | input | 1 | Port choice: 1 = port A, 0 = port B |
| smp_valid | input | 1 | New sample pair present |
| smp_i | input | 15 | In-phase sample, two's complement |
| smp_q | input | 15 | Quadrature sample, two's complement |
| streaming | output | 1 | Streaming active |
| fs_a | output | 1 | Port A frame sync |
| sd_a | output | 1 | Port A serial data |
| fs_b | output | 1 | Port B frame sync |
| sd_b | output | 1 | Port B serial data |

## Verification
The bench is run through several phases:
- **Fresh pair every slot, register enable:** walks random sample values through the word bits, the flag and the slot timing.
- **Select toggled mid-stream:** separates a select captured at start from one followed live.
- **Starved input:** one pair followed by several empty slots shows whether the held pair is sent again or the data goes to zero.
- **Pin enable on port B with extreme values (most negative, most positive, minus one):** exposes sign-bit and flag-position slips.
- **Valid held high every cycle:** shows which pair a slot boundary captures.

// File: rtl/iqs_pkg.sv
package iqs_pkg;
  localparam int unsigned SMP_W  = 15;
  localparam int unsigned WORD_W = SMP_W + 1;

  typedef logic [SMP_W-1:0]  sample_t;
  typedef logic [WORD_W-1:0] word_t;

  // Sample in the upper bits, in-phase/quadrature flag in bit 0.
  function automatic word_t pack_word(sample_t s, logic q_flag);
    return {s, q_flag};
  endfunction
endpackage

// File: rtl/iqs_slot_timer.sv
module iqs_slot_timer #(
  parameter int unsigned SLOT_CYCLES = 48,
  localparam int unsigned HALF  = SLOT_CYCLES / 2,
  localparam int unsigned CNT_W = $clog2(SLOT_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stream_en,
  output logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             start_evt,
  output logic             load_i_evt,
  output logic             load_q_evt
);
  logic at_end;

  assign at_end     = (cnt == CNT_W'(SLOT_CYCLES - 1));
  assign start_evt  = !run && stream_en;
  assign load_i_evt = start_evt || (run && stream_en && at_end);
  assign load_q_evt = run && stream_en && (cnt == CNT_W'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start_evt) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run && !stream_en) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (run) begin
      cnt <= at_end ? '0 : cnt + 1'b1;
    end
  end

  p_slot_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stream_en && at_end) |=> (cnt == '0));
  p_start_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (run && cnt == '0));
endmodule

// File: rtl/iqs_pair_hold.sv
module iqs_pair_hold
  import iqs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    smp_valid,
  input  sample_t smp_i,
  input  sample_t smp_q,
  input  logic    capture,
  output word_t   i_word,
  output word_t   q_word
);
  sample_t held_i, held_q, lat_i, lat_q;

  assign lat_i  = smp_valid ? smp_i : held_i;
  assign lat_q  = smp_valid ? smp_q : held_q;
  assign i_word = pack_word(lat_i, 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_i <= '0;
      held_q <= '0;
      q_word <= '0;
    end else begin
      if (smp_valid) begin
        held_i <= smp_i;
        held_q <= smp_q;
      end
      if (capture) q_word <= pack_word(lat_q, 1'b1);
    end
  end

  p_resend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !capture) |=> $stable(q_word));
endmodule

// File: rtl/iqs_word_shifter.sv
module iqs_word_shifter
  import iqs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hush,
  input  logic  load_i,
  input  logic  load_q,
  input  word_t i_word,
  input  word_t q_word,
  output logic  ser_bit,
  output logic  word_start
);
  word_t sh;

  assign ser_bit = sh[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh         <= '0;
      word_start <= 1'b0;
    end else if (load_i) begin
      sh         <= i_word;
      word_start <= 1'b1;
    end else if (load_q) begin
      sh         <= q_word;
      word_start <= 1'b1;
    end else if (hush) begin
      sh         <= '0;
      word_start <= 1'b0;
    end else begin
      sh         <= {sh[WORD_W-2:0], 1'b0};
      word_start <= 1'b0;
    end
  end

  p_fs_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |=> !word_start);
endmodule

// File: rtl/iqs_port_router.sv
module iqs_port_router (
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic port_sel,
  input  logic run,
  input  logic ser_bit,
  input  logic word_start,
  output logic fs_a,
  output logic sd_a,
  output logic fs_b,
  output logic sd_b
);
  localparam int unsigned N_PORTS = 2;

  logic               sel_q;
  logic [N_PORTS-1:0] fs_v, sd_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_q <= 1'b0;
    else if (start_evt) sel_q <= port_sel;
  end

  // index 1 is port A (select 1), index 0 is port B (select 0)
  for (genvar gp = 0; gp < N_PORTS; gp++) begin : g_port
    assign fs_v[gp] = run && (sel_q == 1'(gp)) && word_start;
    assign sd_v[gp] = run && (sel_q == 1'(gp)) && ser_bit;
  end

  assign fs_a = fs_v[1];
  assign sd_a = sd_v[1];
  assign fs_b = fs_v[0];
  assign sd_b = sd_v[0];

  p_one_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fs_a | sd_a, fs_b | sd_b}));
  p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start_evt) |=> $stable(sel_q));
endmodule

// File: rtl/iq_word_serializer.sv
module iq_word_serializer
  import iqs_pkg::*;
#(
  parameter int unsigned SLOT_CYCLES = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_reg,
  input  logic             en_pin,
  input  logic             port_sel,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_i,
  input  logic [SMP_W-1:0] smp_q,
  output logic             streaming,
  output logic             fs_a,
  output logic             sd_a,
  output logic             fs_b,
  output logic             sd_b
);
  localparam int unsigned HALF  = SLOT_CYCLES / 2;
  localparam int unsigned CNT_W = $clog2(SLOT_CYCLES);

  logic             stream_en, run, start_evt, load_i_evt, load_q_evt;
  logic [CNT_W-1:0] cnt;
  word_t            i_word, q_word;
  logic             ser_bit, word_start;

  assign stream_en = en_reg | en_pin;
  assign streaming = run;

  iqs_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .stream_en(stream_en), .run(run), .cnt(cnt),
    .start_evt(start_evt), .load_i_evt(load_i_evt), .load_q_evt(load_q_evt));

  iqs_pair_hold u_hold (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i),
    .smp_q(smp_q), .capture(load_i_evt), .i_word(i_word), .q_word(q_word));

  iqs_word_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .hush(!stream_en), .load_i(load_i_evt),
    .load_q(load_q_evt), .i_word(i_word), .q_word(q_word),
    .ser_bit(ser_bit), .word_start(word_start));

  iqs_port_router u_route (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .port_sel(port_sel),
    .run(run), .ser_bit(ser_bit), .word_start(word_start),
    .fs_a(fs_a), .sd_a(sd_a), .fs_b(fs_b), .sd_b(sd_b));

  p_stop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !stream_en) |=> !(streaming || fs_a || sd_a || fs_b || sd_b));
  p_flag_i_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == CNT_W'(WORD_W - 1)) |-> !ser_bit);
  p_flag_q_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == CNT_W'(HALF + WORD_W - 1)) |-> ser_bit);
  p_fs_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |-> (cnt == '0 || cnt == CNT_W'(HALF)));
endmodule

// File: tb/iq_word_serializer_test.sv
module iq_word_serializer_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 48;
  localparam int HALF = SLOT / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_reg = 1'b0, en_pin = 1'b0, port_sel = 1'b0, smp_valid = 1'b0;
  logic [14:0] smp_i = '0, smp_q = '0;
  logic streaming, fs_a, sd_a, fs_b, sd_b;

  int checks = 0, errors = 0, cyc = 0;
  string ph = "R4";

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_word_serializer #(.SLOT_CYCLES(SLOT)) uut (
    .clk(clk), .rst_n(rst_n), .en_reg(en_reg), .en_pin(en_pin),
    .port_sel(port_sel), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .streaming(streaming), .fs_a(fs_a), .sd_a(sd_a), .fs_b(fs_b), .sd_b(sd_b));

  // reference model: slot position indexed, words kept as integers
  bit mrun = 0, msel = 0;
  int mpos = 0;
  logic [14:0] mhi = '0, mhq = '0;
  logic [15:0] mwi = '0, mwq = '0;

  always @(posedge clk) begin
    logic [14:0] li, lq;
    cyc++;
    if (!rst_n) begin
      mrun = 0; mpos = 0; mhi = '0; mhq = '0;
    end else begin
      li = smp_valid ? smp_i : mhi;
      lq = smp_valid ? smp_q : mhq;
      if (!mrun && (en_reg || en_pin)) begin
        mrun = 1; msel = port_sel; mpos = 0;
      end else if (mrun && !(en_reg || en_pin)) mrun = 0;
      else if (mrun) mpos = (mpos + 1) % SLOT;
      if (mrun && mpos == 0) begin
        mwi = {li, 1'b0};
        mwq = {lq, 1'b1};
      end
      if (smp_valid) begin mhi = smp_i; mhq = smp_q; end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cyc=%0d pos=%0d actual=%0d expected=%0d", tag, cyc, mpos, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit efs, esd;
    if (!rst_n) begin
      chk({streaming, fs_a, sd_a, fs_b, sd_b} == 5'b0, "R10 reset",
          int'({streaming, fs_a, sd_a, fs_b, sd_b}), 0);
    end else begin
      efs = mrun && (mpos == 0 || mpos == HALF);
      esd = 1'b0;
      if (mrun && mpos < 16) esd = mwi[15 - mpos];
      else if (mrun && mpos >= HALF && mpos < HALF + 16) esd = mwq[HALF + 15 - mpos];
      chk(streaming == mrun, {"R5 ", ph}, int'(streaming), int'(mrun));
      chk((msel ? fs_a : fs_b) == efs,
          {(mpos == HALF) ? "R3 " : "R9 ", ph}, int'(msel ? fs_a : fs_b), int'(efs));
      chk((msel ? sd_a : sd_b) == esd,
          {(mpos == 15 || mpos == HALF + 15) ? "R2 " : "R1 ", ph},
          int'(msel ? sd_a : sd_b), int'(esd));
      chk((msel ? (fs_b | sd_b) : (fs_a | sd_a)) == 1'b0, {"R6 ", ph},
          int'(msel ? (fs_b | sd_b) : (fs_a | sd_a)), 0);
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // one new pair at the start of each of n slots, valid for one cycle
  task automatic feed_slots(int n);
    for (int s = 0; s < n; s++) begin
      smp_i = 15'($urandom); smp_q = 15'($urandom); smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      idle(SLOT - 1);
    end
  endtask

  initial begin
    idle(4);                        // R10: outputs checked low during reset
    rst_n = 1'b1;
    idle(6);
    ph = "R4"; port_sel = 1'b1; en_reg = 1'b1;   // R6: port A
    feed_slots(4);
    ph = "R7"; port_sel = 1'b0;     // ignored mid-stream
    feed_slots(3);
    ph = "R5"; en_reg = 1'b0;       // stop
    idle(20);
    ph = "R6"; port_sel = 1'b0; en_pin = 1'b1;   // pin enable, port B
    smp_i = 15'h4000; smp_q = 15'h3FFF; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    ph = "R8"; port_sel = 1'b1;     // starved slots resend held pair
    idle(3 * SLOT);
    ph = "R1"; smp_i = 15'h7FFF; smp_q = 15'h0001; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    idle(2 * SLOT);
    ph = "R8";                      // valid every cycle
    for (int k = 0; k < 3 * SLOT; k++) begin
      smp_i = 15'($urandom); smp_q = 15'($urandom); smp_valid = 1'b1;
      @(negedge clk);
    end
    smp_valid = 1'b0;
    ph = "R5"; en_pin = 1'b0;
    idle(10);
    ph = "R5"; en_reg = 1'b1; en_pin = 1'b1;     // both enables
    feed_slots(2);
    en_reg = 1'b0; en_pin = 1'b0;
    idle(10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule